// File: doc/BRIEF.md
# Burst-Gated SPI Master

This block is an SPI master whose serial clock is not a free-running divided clock. The clock pin is the bit stream of a 16-bit pattern shifter loaded with alternating ones and zeros. The shifter advances once per pattern-bit period, which is `div` system clocks. Each load therefore yields exactly eight clock cycles, one byte. When the shifter is empty, the clock sits low. Between bursts nothing toggles, so chip select needs no alignment to any clock edge and simply follows system-clock timing.

The data lines are not timed from the double-rate pattern. The generated clock is fed back through a delay of `FB_DELAY` system clocks, which models the pad return path. MOSI shifts on the fed-back falling edge and MISO is sampled on the fed-back rising edge. Each byte is therefore shifted once: transmit bits are not duplicated and receive bits are not thinned out. The bus runs in mode 0, MSB first.

The host presents the first transmit byte, a byte count and the divider, then pulses `start`. The block pulses `tx_pop` each time it takes the byte on `tx_data`, so the host then presents the next byte. Each received byte appears with a one-cycle `rx_valid`. For correct data, `div` must be at least `FB_DELAY + 2`. For example, a 25 MHz bus clock from a 500 MHz system clock uses `div` = 10.

Top module: `spi_pattern_master`

## Requirements
- R1: After reset, `cs_n` is high, while `sclk`, `busy`, `rx_valid` and `tx_pop` are low.
- R2: A transfer of N bytes produces exactly 8·N rising edges of `sclk`. Consecutive bytes follow each other with no pause in the clock.
- R3: `sclk` is low and makes no transition while `cs_n` is high.
- R4: Every high and every low phase of `sclk` lasts exactly `div` system clocks, and a `div` of 0 acts as 1. `div` is captured when a transfer is accepted, and later changes have no effect on that transfer.
- R5: A slave that samples MOSI on rising `sclk` edges receives the transmit bytes in order, bit 7 first. The first bit is valid before the first rising edge.
- R6: MISO is sampled on each rising edge, and the bits are assembled MSB first. After the eighth bit of each byte, `rx_data` holds that byte while `rx_valid` is high for exactly one cycle, giving N pulses per transfer.
- R7: `cs_n` falls one cycle after `start` is accepted. The first rising edge of `sclk` comes 2·`div` cycles after `cs_n` falls. `cs_n` rises `div` cycles after the last falling edge.
- R8: `busy` is high from acceptance until one cycle after `cs_n` rises, and is high whenever `cs_n` is low.
- R9: `start` is ignored while `busy` is high or while `len` is 0.
- R10: `tx_pop` pulses for one cycle each time a transmit byte is taken. The first byte is taken at acceptance, and there are N pulses per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | DIV_W | Pattern-bit period in system clocks (half an SCLK period) |
| start | input | 1 | Request to begin a transfer |
| len | input | LEN_W | Number of bytes in the transfer |
| tx_data | input | 8 | Transmit byte currently offered by the host |
| tx_pop | output | 1 | One-cycle pulse: `tx_data` was taken |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` is new |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Generated serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low chip select |

## Verification
Chip select falls one cycle after the cycle in which `start` is seen. The first clock rise follows 2·`div` cycles later, and every clock phase after that lasts `div` cycles. Chip select rises `div` cycles after the last fall, and `busy` drops one cycle after that. The bench drives inputs just after a rising edge and logs, on falling edges, the cycle number of every chip-select, clock and busy transition. Each of these timings is then checked as an exact cycle difference, not as a window. Received bytes arrive `FB_DELAY + 1` cycles after their eighth rising edge. With `div` at least `FB_DELAY + 2`, both they and the transmit bytes seen by the modelled slave are compared only after `busy` drops, against values computed from the per-run seed.

// File: rtl/spi_pattern_master.sv
module spi_pattern_master #(
  parameter int DIV_W    = 8,
  parameter int LEN_W    = 8,
  parameter int FB_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int BYTE_BITS = 8;
  localparam int PAT_BITS  = 2 * BYTE_BITS;
  localparam int PCNT_W    = $clog2(PAT_BITS + 1);
  localparam int BCNT_W    = $clog2(BYTE_BITS);

  function automatic logic [PAT_BITS-1:0] alt_pattern();
    logic [PAT_BITS-1:0] p;
    for (int i = 0; i < PAT_BITS; i++) p[i] = ((i % 2) == 0);
    return p;
  endfunction

  localparam logic [PAT_BITS-1:0] PATTERN = alt_pattern();

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_RUN, S_TRAIL, S_FIN} state_t;

  state_t              state;
  logic [DIV_W-1:0]    div_q, tcnt;
  logic [PAT_BITS-1:0] pat;
  logic [PCNT_W-1:0]   pat_left;
  logic [LEN_W-1:0]    words_left, tx_left;
  logic                accept, tick;

  assign accept = (state == S_IDLE) && start && (len != '0);
  assign tick   = (state != S_IDLE) && (tcnt == div_q - 1'b1);

  // pattern-clock generator and chip-select sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cs_n       <= 1'b1;
      busy       <= 1'b0;
      sclk       <= 1'b0;
      pat        <= '0;
      pat_left   <= '0;
      words_left <= '0;
      div_q      <= DIV_W'(1);
      tcnt       <= '0;
    end else begin
      tcnt <= (state == S_IDLE || tick) ? '0 : tcnt + 1'b1;
      case (state)
        S_IDLE: if (accept) begin
          state      <= S_LEAD;
          cs_n       <= 1'b0;
          busy       <= 1'b1;
          div_q      <= (div == '0) ? DIV_W'(1) : div;
          words_left <= len - 1'b1;
        end
        S_LEAD: if (tick) begin
          state    <= S_RUN;
          sclk     <= PATTERN[PAT_BITS-1];
          pat      <= PATTERN << 1;
          pat_left <= PCNT_W'(PAT_BITS - 1);
        end
        S_RUN: if (tick) begin
          if (pat_left != '0) begin
            sclk     <= pat[PAT_BITS-1];
            pat      <= pat << 1;
            pat_left <= pat_left - 1'b1;
          end else if (words_left != '0) begin
            sclk       <= PATTERN[PAT_BITS-1];
            pat        <= PATTERN << 1;
            pat_left   <= PCNT_W'(PAT_BITS - 1);
            words_left <= words_left - 1'b1;
          end else begin
            sclk  <= 1'b0;
            state <= S_TRAIL;
          end
        end
        S_TRAIL: if (tick) begin
          cs_n  <= 1'b1;
          state <= S_FIN;
        end
        S_FIN: begin
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // fed-back clock: the data lines follow this delayed copy
  logic [FB_DELAY-1:0] fb;
  logic                fb_prev, fb_rise, fb_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb      <= '0;
      fb_prev <= 1'b0;
    end else begin
      fb      <= FB_DELAY'({fb, sclk});
      fb_prev <= fb[FB_DELAY-1];
    end
  end

  assign fb_rise = fb[FB_DELAY-1] & ~fb_prev;
  assign fb_fall = ~fb[FB_DELAY-1] & fb_prev;

  // byte shifters clocked by the fed-back edges
  logic [7:0]        tx_sh;
  logic [6:0]        rx_sh;
  logic [BCNT_W-1:0] rcnt, fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      rcnt     <= '0;
      fcnt     <= '0;
      tx_left  <= '0;
      tx_pop   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      tx_pop   <= 1'b0;
      rx_valid <= 1'b0;
      if (accept) begin
        tx_sh   <= tx_data;
        tx_pop  <= 1'b1;
        tx_left <= LEN_W'(len - 1'b1);
        rcnt    <= '0;
        fcnt    <= '0;
      end else begin
        if (fb_rise) begin
          rx_sh <= {rx_sh[5:0], miso};
          rcnt  <= rcnt + 1'b1;
          if (rcnt == BCNT_W'(BYTE_BITS - 1)) begin
            rx_data  <= {rx_sh, miso};
            rx_valid <= 1'b1;
          end
        end
        if (fb_fall) begin
          fcnt <= fcnt + 1'b1;
          if (fcnt == BCNT_W'(BYTE_BITS - 1) && tx_left != '0) begin
            tx_sh   <= tx_data;
            tx_pop  <= 1'b1;
            tx_left <= tx_left - 1'b1;
          end else begin
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi = tx_sh[7];

  a_r3_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r3_no_edge_while_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> !cs_n);
  a_r8_busy_covers_select: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  a_r8_busy_drops_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cs_n && $past(cs_n)));
  a_r6_rx_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r10_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !tx_pop);
  a_r4_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));
endmodule

// File: tb/spi_pattern_master_bench.sv
module spi_pattern_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FB_DELAY   = 2;
  // {len[19:16], div[15:8], seed[7:0]}
  localparam logic [19:0] VEC [4] = '{
    {4'd1, 8'd4,  8'hA5},
    {4'd2, 8'd5,  8'h3C},
    {4'd3, 8'd7,  8'h0F},
    {4'd4, 8'd10, 8'h96}
  };

  logic clk = 1'b0, rst_n, start, miso;
  logic [7:0] div_in, len, tx_data, rx_data;
  logic tx_pop, rx_valid, busy, sclk, mosi, cs_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_pattern_master #(.DIV_W(8), .LEN_W(8), .FB_DELAY(FB_DELAY)) u_spi_pattern_master (
    .clk(clk), .rst_n(rst_n), .div(div_in), .start(start), .len(len),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int n_chk = 0, n_bad = 0;
  logic [7:0] tx_mem [16];
  logic [7:0] sl_mem [16];
  logic [7:0] cap    [16];
  logic [7:0] rx_got [16];
  logic [7:0] cap_sh;
  int cyc = 0, tx_idx = 0, rx_cnt, pop_cnt, n_rise, half_bad, idle_edge, exp_half, last_edge;
  int t_start, t_csfall, t_csrise, t_first_rise, t_last_fall, t_busyfall;
  int rbit, rbyte;
  bit have_edge, done;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_busy = 1'b0;

  assign tx_data = tx_mem[4'(tx_idx)];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_cnt = 0; pop_cnt = 0; n_rise = 0; half_bad = 0; idle_edge = 0; tx_idx = 0;
    have_edge = 0; done = 0; last_edge = 0; rbit = 0; rbyte = 0;
    t_start = -1; t_csfall = -1; t_csrise = -1; t_first_rise = -1; t_last_fall = -1; t_busyfall = -1;
  endtask

  // monitor on falling system-clock edges
  always @(negedge clk) begin
    cyc++;
    if (start && !busy && len != 0 && t_start < 0) t_start = cyc;
    if (prev_cs && !cs_n) t_csfall = cyc;
    if (!prev_cs && cs_n) t_csrise = cyc;
    if (sclk != prev_sclk) begin
      if (cs_n) idle_edge++;
      if (have_edge && (cyc - last_edge) != exp_half) half_bad++;
      last_edge = cyc;
      have_edge = 1;
      if (sclk) begin
        n_rise++;
        if (t_first_rise < 0) t_first_rise = cyc;
      end else t_last_fall = cyc;
    end
    if (prev_busy && !busy) begin t_busyfall = cyc; done = 1; end
    if (rx_valid) begin rx_got[rx_cnt % 16] = rx_data; rx_cnt++; end
    if (tx_pop) begin pop_cnt++; tx_idx++; end
    prev_cs = cs_n; prev_sclk = sclk; prev_busy = busy;
  end

  // mode-0 slave model
  always @(posedge sclk) begin
    cap_sh = {cap_sh[6:0], mosi};
    if (rbit == 7) begin cap[rbyte % 16] = cap_sh; rbyte++; rbit = 0; end
    else rbit++;
  end
  always @(negedge sclk or negedge cs_n) miso = sl_mem[rbyte % 16][7 - rbit];

  task automatic run(input int n, input int d, input logic [7:0] seed, input bit chk_data, input bit poke);
    int eff;
    eff = (d == 0) ? 1 : d;
    for (int k = 0; k < 16; k++) begin
      tx_mem[k] = 8'(seed + 37 * k);
      sl_mem[k] = 8'(~seed ^ (8'h53 * k));
    end
    @(posedge clk); #1;
    clear_mon();
    exp_half = eff;
    len = 8'(n); div_in = 8'(d); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (poke) begin
      repeat (30) @(posedge clk);
      #1 start = 1'b1; len = 8'd5; div_in = 8'd9;
      @(posedge clk); #1 start = 1'b0;
    end
    wait (done);
    repeat (4) @(negedge clk);
    check("R2 rising edges", n_rise, 8 * n);
    check("R4 phase length", half_bad, 0);
    check("R3 edges while deselected", idle_edge, 0);
    check("R7 cs after start", t_csfall - t_start, 1);
    check("R7 lead to first rise", t_first_rise - t_csfall, 2 * eff);
    check("R7 trail after last fall", t_csrise - t_last_fall, eff);
    check("R8 busy after release", t_busyfall - t_csrise, 1);
    check("R10 pops", pop_cnt, n);
    check("R6 rx pulses", rx_cnt, n);
    if (chk_data)
      for (int k = 0; k < n; k++) begin
        check("R5 slave got tx byte", int'(cap[k]), int'(tx_mem[k]));
        check("R6 rx byte", int'(rx_got[k]), int'(sl_mem[k]));
      end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_mon();
    exp_half = 1;
    rst_n = 1'b0; start = 1'b0; len = '0; div_in = 8'd4; miso = 1'b0; cap_sh = '0;
    for (int k = 0; k < 16; k++) begin tx_mem[k] = '0; sl_mem[k] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 sclk", int'(sclk), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 rx_valid", int'(rx_valid), 0);
    check("R1 tx_pop", int'(tx_pop), 0);

    @(posedge clk); #1;
    clear_mon();
    start = 1'b1; len = 8'd0;
    @(posedge clk); #1 start = 1'b0;
    repeat (12) @(negedge clk);
    check("R9 zero length busy", int'(busy), 0);
    check("R9 zero length cs", int'(cs_n), 1);
    check("R9 zero length pops", pop_cnt, 0);

    for (int i = 0; i < 4; i++)
      run(int'(VEC[i][19:16]), int'(VEC[i][15:8]), VEC[i][7:0], 1'b1, 1'b0);
    run(2, 6, 8'h5A, 1'b1, 1'b1);   // R9 restart and R4 divider change while busy
    run(1, 0, 8'hC3, 1'b0, 1'b0);   // R4 divider 0 acts as 1
    run(6, 4, 8'h71, 1'b1, 1'b0);   // R2 long back-to-back burst

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule